// File: doc/BRIEF.md
# Dual-Buffer Frame Transmit Controller

This block is the transmit half of a small memory-mapped Ethernet MAC. Software writes frame bytes into one of two packet buffers over a 32-bit word bus. It sets that buffer's byte count and then writes the buffer's control word. Depending on two bits of that write, the block either streams the buffer out on a byte-wide valid/ready/last interface, or copies the first six bytes of the buffer into the 48-bit station address output. The station address output feeds the receive-side address filter.

A buffer stays busy from the starting write until its operation completes. Software learns that the buffer is free again by polling the start bit, which clears by itself. When an operation completes, a single-cycle interrupt pulse is produced. The pulse needs both the buffer's own interrupt-enable bit and one global enable bit held in buffer 0's register group. Preamble, FCS and the receive path belong to other blocks.

Top module: `ethtx_ctrl`

## Requirements
- R1: With B = 2^BUF_AW, buffer b (0 or 1) occupies bytes b·B to b·B+B−1. Its byte count register is at b·B+B−12, reads back its low BUF_AW bits and reads 0 above them. Its control register is at b·B+B−4 and reads S in bit 0, P in bit 1, I in bit 3 and zero elsewhere. A global enable register exists only at B−8 in buffer 0 and keeps bit 31 only. Every other word reads back the value last written to it. Bus address bits 1:0 are ignored.
- R2: After reset, both control registers, both count registers and the global enable read 0, `station_mac` is 0, and `tx_valid` and `irq` are low.
- R3: A control write with bit 0 = 1 and bit 1 = 0 streams the count's number of bytes from the buffer's first byte upward. Within each word, bits 7:0 go first. `tx_last` is high on the final byte only. While `tx_ready` is low, `tx_data` and `tx_last` hold.
- R4: A control write with bit 0 = 1 and bit 1 = 1 sends no bytes. It loads `station_mac` so that buffer byte k lands in bits 8k+7:8k, for k = 0 to 5. `station_mac` changes at no other time.
- R5: The control register reads S = 1 from the cycle after a starting write until the operation completes. After completion it reads S = 0 and P = 0, while I keeps the value written with the start.
- R6: A write to a control register whose S bit reads 1 has no effect on that register.
- R7: On completion, `irq` is high for exactly one cycle if and only if the buffer's I bit and bit 31 of the global enable are both 1.
- R8: When both buffers are pending, buffer 0 is served first. Each frame finishes its last byte before the other buffer starts.
- R9: A send with a byte count of 0 completes, clears S and may pulse `irq`, with no byte transferred.
- R10: A control write with bit 0 = 0 starts nothing. It stores only the I bit, and P reads 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Word write strobe |
| bus_rd | input | 1 | Word read strobe; data returns on the next cycle |
| bus_addr | input | BUF_AW+1 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tx_data | output | 8 | Frame byte |
| tx_valid | output | 1 | Byte valid |
| tx_ready | input | 1 | Sink accepts the byte |
| tx_last | output | 1 | Final byte of the frame |
| station_mac | output | 48 | Loaded station address |
| irq | output | 1 | Completion interrupt pulse |

## Verification
The bench builds the block with BUF_AW = 6. This gives 64-byte buffers with the count, enable and control words at 0x34, 0x38 and 0x3C (0x74 and 0x7C for buffer 1). Both register groups and the end of the data area are therefore reached with short bus sequences. The narrow 6-bit count field puts the count-truncation case and a second buffer's decode within a few writes. A stalled sink shows the busy lock, and a pseudo-random sink shows the held-byte behaviour across many stalls.

// File: rtl/ethtx_pkg.sv
package ethtx_pkg;
   localparam int CTL_S_BIT = 0;
   localparam int CTL_P_BIT = 1;
   localparam int CTL_I_BIT = 3;
   localparam int GIE_BIT   = 31;
   localparam int BUS_W     = 32;
   localparam int MAC_W     = 48;

   typedef enum logic [1:0] {
      ENG_IDLE = 2'd0,
      ENG_SEND = 2'd1,
      ENG_MAC  = 2'd2,
      ENG_DONE = 2'd3
   } eng_state_e;
endpackage

// File: rtl/ethtx_ctlreg.sv
module ethtx_ctlreg #(
   parameter int LEN_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_we,
   input  logic             ctl_s,
   input  logic             ctl_p,
   input  logic             ctl_i,
   input  logic             len_we,
   input  logic [LEN_W-1:0] len_wdata,
   input  logic             done,
   output logic             busy_o,
   output logic             prog_o,
   output logic             ien_o,
   output logic [LEN_W-1:0] len_o
);
   logic             busy_q, prog_q, ien_q;
   logic [LEN_W-1:0] len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         prog_q <= 1'b0;
         ien_q  <= 1'b0;
      end else if (done) begin
         busy_q <= 1'b0;
         prog_q <= 1'b0;
      end else if (ctl_we && !busy_q) begin
         busy_q <= ctl_s;
         prog_q <= ctl_s & ctl_p;
         ien_q  <= ctl_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      len_q <= '0;
      else if (len_we) len_q <= len_wdata;
   end

   assign busy_o = busy_q;
   assign prog_o = prog_q;
   assign ien_o  = ien_q;
   assign len_o  = len_q;
endmodule

// File: rtl/ethtx_bufmem.sv
module ethtx_bufmem #(
   parameter int WORD_AW = 9,
   parameter int DW      = 32
) (
   input  logic               clk,
   input  logic               we,
   input  logic               wsel,
   input  logic [WORD_AW-1:0] widx,
   input  logic [DW-1:0]      wdata,
   input  logic               rsel,
   input  logic [WORD_AW-1:0] ridx,
   output logic [DW-1:0]      rword,
   input  logic               esel,
   input  logic [WORD_AW-1:0] eidx,
   output logic [DW-1:0]      eword,
   output logic [DW-1:0]      mac_w0,
   output logic [DW-1:0]      mac_w1
);
   localparam int WORDS = 1 << WORD_AW;

   for (genvar b = 0; b < 2; b++) begin : g_bank
      logic [DW-1:0] mem [WORDS];
      logic [DW-1:0] bus_rd_w, eng_rd_w, m0_w, m1_w;

      always_ff @(posedge clk) begin
         if (we && (wsel == 1'(b))) mem[widx] <= wdata;
      end

      assign bus_rd_w = mem[ridx];
      assign eng_rd_w = mem[eidx];
      assign m0_w     = mem[0];
      assign m1_w     = mem[1];
   end

   assign rword  = rsel ? g_bank[1].bus_rd_w : g_bank[0].bus_rd_w;
   assign eword  = esel ? g_bank[1].eng_rd_w : g_bank[0].eng_rd_w;
   assign mac_w0 = esel ? g_bank[1].m0_w     : g_bank[0].m0_w;
   assign mac_w1 = esel ? g_bank[1].m1_w     : g_bank[0].m1_w;
endmodule

// File: rtl/ethtx_engine.sv
module ethtx_engine import ethtx_pkg::*; #(
   parameter int LEN_W = 11,
   localparam int WORD_AW = LEN_W - 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         busy,
   input  logic [1:0]         prog,
   input  logic [1:0]         ien,
   input  logic [LEN_W-1:0]   len0,
   input  logic [LEN_W-1:0]   len1,
   input  logic               gie,
   output logic               eng_sel,
   output logic [WORD_AW-1:0] eng_idx,
   input  logic [BUS_W-1:0]   eword,
   input  logic [BUS_W-1:0]   mac_w0,
   input  logic [BUS_W-1:0]   mac_w1,
   output logic [7:0]         tx_data,
   output logic               tx_valid,
   input  logic               tx_ready,
   output logic               tx_last,
   output logic [MAC_W-1:0]   station_mac,
   output logic               mac_ld,
   output logic               done_vld,
   output logic               done_buf,
   output logic               irq
);
   eng_state_e       st_q;
   logic             sel_q;
   logic [LEN_W-1:0] cnt_q, last_q;
   logic [MAC_W-1:0] mac_q;
   logic             irq_q;
   logic             pick;
   logic [LEN_W-1:0] len_pick;
   logic [15:0]      unused_hi;

   assign pick      = ~busy[0];
   assign len_pick  = pick ? len1 : len0;
   assign unused_hi = mac_w1[31:16];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ENG_IDLE;
         sel_q  <= 1'b0;
         cnt_q  <= '0;
         last_q <= '0;
         mac_q  <= '0;
         irq_q  <= 1'b0;
      end else begin
         irq_q <= (st_q == ENG_DONE) && ien[sel_q] && gie;
         unique case (st_q)
            ENG_IDLE: begin
               if (|busy) begin
                  sel_q  <= pick;
                  cnt_q  <= '0;
                  last_q <= len_pick - LEN_W'(1);
                  if (prog[pick])          st_q <= ENG_MAC;
                  else if (len_pick == '0) st_q <= ENG_DONE;
                  else                     st_q <= ENG_SEND;
               end
            end
            ENG_SEND: begin
               if (tx_ready) begin
                  if (cnt_q == last_q) st_q  <= ENG_DONE;
                  else                 cnt_q <= cnt_q + LEN_W'(1);
               end
            end
            ENG_MAC: begin
               mac_q <= {mac_w1[15:0], mac_w0};
               st_q  <= ENG_DONE;
            end
            ENG_DONE: st_q <= ENG_IDLE;
            default:  st_q <= ENG_IDLE;
         endcase
      end
   end

   assign eng_sel     = sel_q;
   assign eng_idx     = cnt_q[LEN_W-1:2];
   assign tx_data     = eword[{cnt_q[1:0], 3'b000} +: 8];
   assign tx_valid    = (st_q == ENG_SEND);
   assign tx_last     = (st_q == ENG_SEND) && (cnt_q == last_q);
   assign station_mac = mac_q;
   assign mac_ld      = (st_q == ENG_MAC);
   assign done_vld    = (st_q == ENG_DONE);
   assign done_buf    = sel_q;
   assign irq         = irq_q;
endmodule

// File: rtl/ethtx_ctrl.sv
module ethtx_ctrl import ethtx_pkg::*; #(
   parameter int BUF_AW = 11,
   localparam int ADDR_W = BUF_AW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [7:0]        tx_data,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic              tx_last,
   output logic [47:0]       station_mac,
   output logic              irq
);
   localparam int LEN_W   = BUF_AW;
   localparam int WORD_AW = BUF_AW - 2;
   localparam int WORDS   = 1 << WORD_AW;
   localparam logic [WORD_AW-1:0] LEN_IDX = WORD_AW'(WORDS - 3);
   localparam logic [WORD_AW-1:0] GIE_IDX = WORD_AW'(WORDS - 2);
   localparam logic [WORD_AW-1:0] CTL_IDX = WORD_AW'(WORDS - 1);

   if (BUF_AW < 5) begin : g_bad_aw
      $error("BUF_AW must leave room for two address words and three registers");
   end
   if (BUF_AW > 16) begin : g_big_aw
      $error("BUF_AW above 16 gives an unreasonably large buffer");
   end

   logic               bsel;
   logic [WORD_AW-1:0] widx;
   logic               hit_len, hit_gie, hit_ctl, mem_we;
   logic               gie_q;
   logic [1:0]         busy_w, prog_w, ien_w;
   logic [LEN_W-1:0]   len_w [2];
   logic [BUS_W-1:0]   mem_rword, eword, mac_w0, mac_w1;
   logic               eng_sel, done_vld, done_buf, mac_ld;
   logic [WORD_AW-1:0] eng_idx;
   logic [31:0]        rdata_d, rdata_q;
   logic [1:0]         unused_lsb;

   assign unused_lsb = bus_addr[1:0];
   assign bsel    = bus_addr[BUF_AW];
   assign widx    = bus_addr[BUF_AW-1:2];
   assign hit_len = (widx == LEN_IDX);
   assign hit_gie = (widx == GIE_IDX) && !bsel;
   assign hit_ctl = (widx == CTL_IDX);
   assign mem_we  = bus_wr && !hit_len && !hit_ctl && !hit_gie;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  gie_q <= 1'b0;
      else if (bus_wr && hit_gie)  gie_q <= bus_wdata[GIE_BIT];
   end

   for (genvar b = 0; b < 2; b++) begin : g_buf
      ethtx_ctlreg #(.LEN_W(LEN_W)) u_ctl (
         .clk       (clk),
         .rst_n     (rst_n),
         .ctl_we    (bus_wr && hit_ctl && (bsel == 1'(b))),
         .ctl_s     (bus_wdata[CTL_S_BIT]),
         .ctl_p     (bus_wdata[CTL_P_BIT]),
         .ctl_i     (bus_wdata[CTL_I_BIT]),
         .len_we    (bus_wr && hit_len && (bsel == 1'(b))),
         .len_wdata (bus_wdata[LEN_W-1:0]),
         .done      (done_vld && (done_buf == 1'(b))),
         .busy_o    (busy_w[b]),
         .prog_o    (prog_w[b]),
         .ien_o     (ien_w[b]),
         .len_o     (len_w[b])
      );
   end

   ethtx_bufmem #(.WORD_AW(WORD_AW), .DW(BUS_W)) u_mem (
      .clk    (clk),
      .we     (mem_we),
      .wsel   (bsel),
      .widx   (widx),
      .wdata  (bus_wdata),
      .rsel   (bsel),
      .ridx   (widx),
      .rword  (mem_rword),
      .esel   (eng_sel),
      .eidx   (eng_idx),
      .eword  (eword),
      .mac_w0 (mac_w0),
      .mac_w1 (mac_w1)
   );

   ethtx_engine #(.LEN_W(LEN_W)) u_eng (
      .clk         (clk),
      .rst_n       (rst_n),
      .busy        (busy_w),
      .prog        (prog_w),
      .ien         (ien_w),
      .len0        (len_w[0]),
      .len1        (len_w[1]),
      .gie         (gie_q),
      .eng_sel     (eng_sel),
      .eng_idx     (eng_idx),
      .eword       (eword),
      .mac_w0      (mac_w0),
      .mac_w1      (mac_w1),
      .tx_data     (tx_data),
      .tx_valid    (tx_valid),
      .tx_ready    (tx_ready),
      .tx_last     (tx_last),
      .station_mac (station_mac),
      .mac_ld      (mac_ld),
      .done_vld    (done_vld),
      .done_buf    (done_buf),
      .irq         (irq)
   );

   always_comb begin
      rdata_d = mem_rword;
      if (hit_ctl) begin
         rdata_d = '0;
         rdata_d[CTL_S_BIT] = busy_w[bsel];
         rdata_d[CTL_P_BIT] = prog_w[bsel];
         rdata_d[CTL_I_BIT] = ien_w[bsel];
      end else if (hit_len) begin
         rdata_d = 32'(len_w[bsel]);
      end else if (hit_gie) begin
         rdata_d = '0;
         rdata_d[GIE_BIT] = gie_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (bus_rd) rdata_q <= rdata_d;
   end

   assign bus_rdata = rdata_q;
endmodule

// File: rtl/ethtx_ctrl_chk.sv
module ethtx_ctrl_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        tx_valid,
   input logic        tx_ready,
   input logic        tx_last,
   input logic [7:0]  tx_data,
   input logic        irq,
   input logic        gie,
   input logic [1:0]  busy,
   input logic [47:0] station_mac,
   input logic        mac_ld
);
   // R7: pulse lasts one cycle
   a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   // R7: pulse needs the global enable in the previous cycle
   a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(gie));

   // R3: stalled byte stays put
   a_r3_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

   // R5: bytes only flow while some buffer reads busy
   a_r5_stream_busy: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> (busy != 2'b00));

   // R4: station address moves only after a load cycle
   a_r4_mac_only_load: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(station_mac) |-> $past(mac_ld));
endmodule

bind ethtx_ctrl ethtx_ctrl_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tx_valid    (tx_valid),
   .tx_ready    (tx_ready),
   .tx_last     (tx_last),
   .tx_data     (tx_data),
   .irq         (irq),
   .gie         (gie_q),
   .busy        (busy_w),
   .station_mac (station_mac),
   .mac_ld      (mac_ld)
);

// File: tb/ethtx_ctrl_bench.sv
`timescale 1ns/1ps
module ethtx_ctrl_bench;
   localparam int AW = 6;
   localparam int XW = AW + 1;
   localparam logic [XW-1:0] A_LEN0 = 7'h34, A_GIE = 7'h38, A_CTL0 = 7'h3C;
   localparam logic [XW-1:0] A_B1 = 7'h40, A_LEN1 = 7'h74, A_CTL1 = 7'h7C;

   logic clk = 0, rst_n = 0;
   logic bus_wr = 0, bus_rd = 0, tx_ready = 0;
   logic [XW-1:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic [7:0] tx_data;
   logic tx_valid, tx_last, irq;
   logic [47:0] station_mac;

   int tests = 0, fails = 0, irq_cnt = 0, rdy_mode = 0;
   logic irq_prev = 0;
   logic [15:0] lfsr = 16'hACE1;
   logic [8:0] exp_q[$];
   logic [31:0] rv;
   bit done_flag = 0;

   always #2 clk = ~clk;

   ethtx_ctrl #(.BUF_AW(AW)) u_ethtx_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .tx_last(tx_last), .station_mac(station_mac), .irq(irq));

   task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] expv);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   task automatic wr(logic [XW-1:0] a, logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1;
      @(negedge clk);
      bus_wr = 0;
   endtask

   task automatic rd(logic [XW-1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1;
      @(negedge clk);
      bus_rd = 0;
      d = bus_rdata;
   endtask

   task automatic load_frame(int b, int n, int seed);
      for (int w = 0; w < (n + 3) / 4; w++) begin
         logic [31:0] word;
         for (int k = 0; k < 4; k++) word[8*k +: 8] = 8'(seed + 3 * (4 * w + k));
         wr(XW'(b * 64 + 4 * w), word);
      end
      for (int k = 0; k < n; k++) exp_q.push_back({(k == n - 1), 8'(seed + 3 * k)});
   endtask

   task automatic wait_done(logic [XW-1:0] a, string req);
      logic [31:0] d;
      int tries = 0;
      d = 32'h1;
      while (d[0] && tries < 2000) begin
         rd(a, d);
         tries++;
      end
      chk(!d[0], req, d, 0);
      repeat (3) @(negedge clk);
   endtask

   // sink readiness, changed just after each rising edge
   initial forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tx_ready = (rdy_mode == 1) ? 1'b1 : (rdy_mode == 2) ? lfsr[0] : 1'b0;
   end

   // per-cycle reference comparison of the byte stream and the interrupt
   always @(negedge clk) begin
      if (rst_n) begin
         if (tx_valid && tx_ready) begin
            if (exp_q.size() == 0) chk(0, "R3 unexpected byte", {tx_last, tx_data}, 0);
            else begin
               logic [8:0] e;
               e = exp_q.pop_front();
               chk(tx_data == e[7:0] && tx_last == e[8], "R3 byte/last", {tx_last, tx_data}, e);
            end
         end
         if (irq) begin
            irq_cnt++;
            if (irq_prev) chk(0, "R7 irq wider than one cycle", 2, 1);
         end
         irq_prev <= irq;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done_flag) begin
         tests++; fails++;
         $display("FAIL watchdog expired");
         summary();
      end
   end

   initial begin
      int base;
      repeat (5) @(negedge clk);
      rst_n = 1;
      // R2 reset state
      rd(A_CTL0, rv); chk(rv == 0, "R2 ctl0", rv, 0);
      rd(A_CTL1, rv); chk(rv == 0, "R2 ctl1", rv, 0);
      rd(A_LEN0, rv); chk(rv == 0, "R2 len0", rv, 0);
      rd(A_GIE, rv);  chk(rv == 0, "R2 gie", rv, 0);
      chk(station_mac == 0 && !tx_valid && !irq, "R2 outputs", {station_mac, tx_valid, irq}, 0);
      // R1 map and readback
      wr(A_LEN0, 32'hFFFF_FF45); rd(A_LEN0, rv); chk(rv == 32'h05, "R1 len trunc", rv, 5);
      wr(XW'(A_B1 + 4), 32'hA5A5_1234); rd(XW'(A_B1 + 4), rv);
      chk(rv == 32'hA5A5_1234, "R1 data word", rv, 32'hA5A5_1234);
      wr(A_GIE, 32'h8000_00FF); rd(A_GIE, rv); chk(rv == 32'h8000_0000, "R1 gie", rv, 32'h8000_0000);
      wr(7'h78, 32'h1357_9BDF); rd(7'h78, rv); chk(rv == 32'h1357_9BDF, "R1 buf1 word at B-8", rv, 32'h1357_9BDF);
      rd(A_GIE, rv); chk(rv == 32'h8000_0000, "R1 gie only in buffer 0", rv, 32'h8000_0000);
      // R3/R5/R6/R7 send buffer 0 with irq
      rdy_mode = 0;
      wr(A_LEN0, 10); load_frame(0, 10, 8'h10);
      base = irq_cnt;
      wr(A_CTL0, 32'h9);
      rd(A_CTL0, rv); chk(rv == 32'h9, "R5 busy reads S", rv, 9);
      wr(A_CTL0, 32'h2);
      rd(A_CTL0, rv); chk(rv == 32'h9, "R6 write while busy ignored", rv, 9);
      rdy_mode = 2;
      wait_done(A_CTL0, "R5 S clears");
      rd(A_CTL0, rv); chk(rv == 32'h8, "R5 I kept, S/P clear", rv, 8);
      chk(irq_cnt == base + 1, "R7 irq with I and gie", irq_cnt, base + 1);
      chk(exp_q.size() == 0, "R3 all bytes sent", exp_q.size(), 0);
      // buffer 1 without I
      wr(A_LEN1, 7); load_frame(1, 7, 8'h40);
      base = irq_cnt;
      wr(A_CTL1, 32'h1);
      wait_done(A_CTL1, "R5 buf1 S clears");
      chk(irq_cnt == base, "R7 no irq without I", irq_cnt, base);
      chk(exp_q.size() == 0, "R3 buf1 bytes sent", exp_q.size(), 0);
      // R4 address load from buffer 1
      wr(A_B1, 32'h4433_2211); wr(XW'(A_B1 + 4), 32'hFFFF_6655);
      base = irq_cnt;
      wr(A_CTL1, 32'hB);
      wait_done(A_CTL1, "R4 load completes");
      chk(station_mac == 48'h6655_4433_2211, "R4 station_mac", station_mac, 48'h6655_4433_2211);
      chk(irq_cnt == base + 1, "R7 irq after load", irq_cnt, base + 1);
      // R10 write without S
      base = irq_cnt;
      wr(A_CTL0, 32'hA);
      rd(A_CTL0, rv); chk(rv == 32'h8, "R10 only I stored", rv, 8);
      repeat (10) @(negedge clk);
      chk(irq_cnt == base && !tx_valid, "R10 nothing started", irq_cnt, base);
      chk(station_mac == 48'h6655_4433_2211, "R4 mac unchanged", station_mac, 48'h6655_4433_2211);
      // R9 zero length
      wr(A_LEN0, 0);
      wr(A_CTL0, 32'h9);
      wait_done(A_CTL0, "R9 zero length completes");
      chk(irq_cnt == base + 1, "R9 irq on empty send", irq_cnt, base + 1);
      // R7 gie off
      wr(A_GIE, 0); wr(A_LEN0, 3); load_frame(0, 3, 8'h70);
      base = irq_cnt;
      wr(A_CTL0, 32'h9);
      wait_done(A_CTL0, "R7 send with gie off");
      chk(irq_cnt == base, "R7 gie blocks irq", irq_cnt, base);
      chk(exp_q.size() == 0, "R3 short frame sent", exp_q.size(), 0);
      // R8 both pending
      rdy_mode = 0;
      wr(A_LEN0, 5); wr(A_LEN1, 52);
      load_frame(0, 5, 8'h80); load_frame(1, 52, 8'h90);
      wr(A_CTL0, 32'h1); wr(A_CTL1, 32'h1);
      rd(A_CTL1, rv); chk(rv == 32'h1, "R8 buffer 1 waits busy", rv, 1);
      chk(tx_valid && tx_data == 8'h80, "R8 buffer 0 first", tx_data, 8'h80);
      rdy_mode = 1;
      wait_done(A_CTL1, "R8 buffer 1 done");
      chk(exp_q.size() == 0, "R8 both frames in order", exp_q.size(), 0);
      done_flag = 1;
      summary();
   end
endmodule